// File: doc/BRIEF.md
# Ethernet Receive Error Statistics Counters

This block keeps three receive-side error statistics for an Ethernet MAC. One counter tallies frames that completed with a bad frame check sequence. A second tallies the separate bursts during which the PHY drove its receive-error signal. A third tallies frames that completed with fewer than 64 bytes. The receive path supplies one status pulse per completed frame, with a CRC-bad flag and the frame's byte length. The raw PHY receive-error level arrives on its own input.

Software reads the counters through a small register port that has read and write strobes and a word address. Read data is combinational. A write strobe alone clears the addressed counter, so no write-data bus exists. Each counter stops at all-ones rather than wrapping, so software can tell that a count overflowed.

Two small state machines carry the behaviour. The receive-error edge machine has states ER_LOW and ER_HIGH. It moves ER_LOW→ER_HIGH (event "rise", which emits one count pulse) when the registered error input is high, and ER_HIGH→ER_LOW (event "fall") when that input is low. Each counter has states CNT_RUN and CNT_FULL. It moves CNT_RUN→CNT_FULL ("fill") when an increment lands on the value one below all-ones, and CNT_FULL→CNT_RUN ("wipe") on a clear write. A clear write in CNT_RUN ("reset-in-run") zeroes the counter and stays in CNT_RUN.

Top module: `rxstat_counters`

## Requirements
- R1: After reset every counter reads zero.
- R2: The CRC counter (word address 0x0) rises by exactly one on each cycle where rx_frame_done and rx_crc_bad are both high. It does not change otherwise, except by clear or saturation.
- R3: The receive-error counter (address 0x4) rises by exactly one for each low-to-high transition of phy_rx_er, however long the input stays high. The input is registered once, so the new count is readable after the second rising clock edge that follows the input rising.
- R4: The short-frame counter (address 0x8) rises by one on a rx_frame_done cycle whose rx_byte_len is below 64. A length of exactly 64 or more does not count.
- R5: A frame that is both short and CRC-bad increments both counters on the same clock.
- R6: A counter that reaches all-ones keeps that value while further events arrive, until it is cleared.
- R7: A bus_wr cycle to a counter's address clears that counter to zero on the next clock and leaves the other counters unchanged.
- R8: If a clear and an increment hit the same counter on the same clock, the counter ends at zero.
- R9: A read of any address other than 0x0, 0x4 and 0x8 returns zero. A write to such an address changes no counter.
- R10: bus_rdata is zero while bus_rd is low. Reads leave the counters unchanged, so repeated reads return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_frame_done | input | 1 | One-cycle pulse at the end of each received frame |
| rx_crc_bad | input | 1 | CRC-bad flag, valid with rx_frame_done |
| rx_byte_len | input | 16 | Frame length in bytes, valid with rx_frame_done |
| phy_rx_er | input | 1 | Raw PHY receive-error level |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe; clears the addressed counter |
| bus_addr | input | 4 | Byte address of the selected counter |
| bus_rdata | output | 32 | Read data, zero-extended counter value |

## Verification
The hardest condition to reach from the ports is saturation. At 32 bits, a counter needs about four billion events to reach all-ones. The bench therefore places a second copy of the block, built with 4-bit counters, next to the full-width one. The two copies share every input. The narrow copy saturates within a few frames in both directed and random traffic, and it must then hold its value, honour a clear, and start counting again. Long high periods on phy_rx_er, mixed with clear writes in the same cycle as frame events, cover the edge-only counting rule and the rule that a clear beats an increment.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;

    localparam int NUM_CNT  = 3;
    localparam int DATA_W   = 32;
    localparam int WORD_B   = 4;

    typedef enum logic [1:0] {
        SEL_CRC   = 2'd0,
        SEL_RXER  = 2'd1,
        SEL_SHORT = 2'd2
    } cnt_sel_e;

    typedef enum logic {
        ER_LOW  = 1'b0,
        ER_HIGH = 1'b1
    } er_state_e;

    typedef enum logic {
        CNT_RUN  = 1'b0,
        CNT_FULL = 1'b1
    } cnt_state_e;

endpackage

// File: rtl/rxstat_edge_fsm.sv
module rxstat_edge_fsm
    import rxstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic er_in,
    output logic er_rise
);

    logic      er_q;
    er_state_e state_q;
    er_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            er_q    <= 1'b0;
            state_q <= ER_LOW;
        end else begin
            er_q    <= er_in;
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ER_LOW:  if (er_q)  state_d = ER_HIGH;
            ER_HIGH: if (!er_q) state_d = ER_LOW;
            default: state_d = ER_LOW;
        endcase
    end

    always_comb begin
        er_rise = (state_q == ER_LOW) && er_q;
    end

endmodule

// File: rtl/rxstat_sat_counter.sv
module rxstat_sat_counter
    import rxstat_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] value
);

    localparam logic [CNT_W-1:0] NEAR_FULL = {{(CNT_W-1){1'b1}}, 1'b0};

    cnt_state_e       state_q;
    cnt_state_e       state_d;
    logic [CNT_W-1:0] val_q;
    logic [CNT_W-1:0] val_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT_RUN;
            val_q   <= '0;
        end else begin
            state_q <= state_d;
            val_q   <= val_d;
        end
    end

    always_comb begin
        state_d = state_q;
        val_d   = val_q;
        unique case (state_q)
            CNT_RUN: begin
                if (clr) begin
                    val_d = '0;
                end else if (inc) begin
                    val_d = val_q + 1'b1;
                    if (val_q == NEAR_FULL) state_d = CNT_FULL;
                end
            end
            CNT_FULL: begin
                if (clr) begin
                    val_d   = '0;
                    state_d = CNT_RUN;
                end
            end
            default: begin
                val_d   = '0;
                state_d = CNT_RUN;
            end
        endcase
    end

    always_comb begin
        value = val_q;
    end

endmodule

// File: rtl/rxstat_bus_port.sv
module rxstat_bus_port
    import rxstat_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic                            bus_rd,
    input  logic                            bus_wr,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_vals,
    output logic [NUM_CNT-1:0]              clr,
    output logic [DATA_W-1:0]               rdata
);

    logic [NUM_CNT-1:0] hit;

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_dec
        localparam logic [ADDR_W-1:0] OFFSET = ADDR_W'(WORD_B * g);
        assign hit[g] = (bus_addr == OFFSET);
        assign clr[g] = bus_wr && hit[g];
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (bus_rd && hit[i]) rdata = rdata | DATA_W'(cnt_vals[i]);
        end
    end

endmodule

// File: rtl/rxstat_counters.sv
module rxstat_counters
    import rxstat_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 4,
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_frame_done,
    input  logic              rx_crc_bad,
    input  logic [LEN_W-1:0]  rx_byte_len,
    input  logic              phy_rx_er,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_rdata
);

    localparam logic [LEN_W-1:0] SHORT_LIMIT = LEN_W'(MIN_LEN);

    logic                          er_rise;
    logic [NUM_CNT-1:0]            cnt_inc;
    logic [NUM_CNT-1:0]            cnt_clr;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_vals;

    rxstat_edge_fsm u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .er_in   (phy_rx_er),
        .er_rise (er_rise)
    );

    always_comb begin
        cnt_inc            = '0;
        cnt_inc[SEL_CRC]   = rx_frame_done && rx_crc_bad;
        cnt_inc[SEL_RXER]  = er_rise;
        cnt_inc[SEL_SHORT] = rx_frame_done && (rx_byte_len < SHORT_LIMIT);
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        rxstat_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (cnt_inc[g]),
            .clr   (cnt_clr[g]),
            .value (cnt_vals[g])
        );
    end

    rxstat_bus_port #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_bus (
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .cnt_vals (cnt_vals),
        .clr      (cnt_clr),
        .rdata    (bus_rdata)
    );

endmodule

// File: rtl/rxstat_checker.sv
module rxstat_checker
    import rxstat_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 4,
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rx_frame_done,
    input  logic                          rx_crc_bad,
    input  logic [LEN_W-1:0]              rx_byte_len,
    input  logic                          bus_rd,
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [31:0]                   bus_rdata,
    input  logic                          er_rise,
    input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_vals
);

    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic mapped;
    logic wr_crc;
    logic wr_rxer;
    logic wr_short;
    assign mapped   = (bus_addr == ADDR_W'(0)) || (bus_addr == ADDR_W'(4)) ||
                      (bus_addr == ADDR_W'(8));
    assign wr_crc   = bus_wr && (bus_addr == ADDR_W'(0));
    assign wr_rxer  = bus_wr && (bus_addr == ADDR_W'(4));
    assign wr_short = bus_wr && (bus_addr == ADDR_W'(8));

    assert_reset_zero_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (cnt_vals == '0));

    assert_crc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_crc && rx_frame_done && rx_crc_bad && cnt_vals[0] != ALL_ONES)
        |=> cnt_vals[0] == CNT_W'($past(cnt_vals[0]) + 1'b1));

    assert_crc_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_crc && !(rx_frame_done && rx_crc_bad)) |=> $stable(cnt_vals[0]));

    assert_edge_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        er_rise |=> !er_rise);

    assert_rxer_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!er_rise && !wr_rxer) |=> $stable(cnt_vals[1]));

    assert_long_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_short && !(rx_frame_done && rx_byte_len < LEN_W'(MIN_LEN)))
        |=> $stable(cnt_vals[2]));

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_chk
        assert_sat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_vals[g] == ALL_ONES && !(bus_wr && bus_addr == ADDR_W'(4 * g)))
            |=> cnt_vals[g] == ALL_ONES);

        assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_W'(4 * g)) |=> cnt_vals[g] == '0);
    end

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !mapped) |-> bus_rdata == '0);

    assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == '0);

endmodule

bind rxstat_counters rxstat_checker #(
    .CNT_W   (CNT_W),
    .ADDR_W  (ADDR_W),
    .LEN_W   (LEN_W),
    .MIN_LEN (MIN_LEN)
) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_frame_done (rx_frame_done),
    .rx_crc_bad    (rx_crc_bad),
    .rx_byte_len   (rx_byte_len),
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_rdata     (bus_rdata),
    .er_rise       (er_rise),
    .cnt_vals      (cnt_vals)
);

// File: tb/rxstat_counters_test.sv
`timescale 1ns/1ps
module rxstat_counters_test;

    localparam int          CLK_NS  = 20;
    localparam int unsigned MAX_W   = 32'hFFFF_FFFF;
    localparam int unsigned MAX_N   = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_frame_done = 1'b0;
    logic        rx_crc_bad = 1'b0;
    logic [15:0] rx_byte_len = '0;
    logic        phy_rx_er = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] rdata_w;
    logic [31:0] rdata_n;

    int unsigned exp_w [3];
    int unsigned exp_n [3];
    bit          m_er_q;
    bit          m_er_high;
    int          checks = 0;
    int          fails = 0;
    bit          finished = 0;

    always #(CLK_NS / 2) clk = ~clk;

    rxstat_counters uut (
        .clk(clk), .rst_n(rst_n), .rx_frame_done(rx_frame_done),
        .rx_crc_bad(rx_crc_bad), .rx_byte_len(rx_byte_len), .phy_rx_er(phy_rx_er),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_rdata(rdata_w)
    );

    rxstat_counters #(.CNT_W(4)) uut_narrow (
        .clk(clk), .rst_n(rst_n), .rx_frame_done(rx_frame_done),
        .rx_crc_bad(rx_crc_bad), .rx_byte_len(rx_byte_len), .phy_rx_er(phy_rx_er),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_rdata(rdata_n)
    );

    function automatic int unsigned sat_step(int unsigned v, int unsigned lim);
        return (v == lim) ? v : v + 1;
    endfunction

    function automatic int addr_index(logic [3:0] a);
        if (a == 4'h0) return 0;
        if (a == 4'h4) return 1;
        if (a == 4'h8) return 2;
        return -1;
    endfunction

    task automatic compare(string req, string what, int unsigned act, int unsigned expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // one clock with the given inputs; updates the model as of the next edge
    task automatic cyc(bit fd, bit cb, int len, bit er, bit wr, logic [3:0] a);
        bit inc [3];
        bit clr [3];
        rx_frame_done = fd;
        rx_crc_bad    = cb;
        rx_byte_len   = 16'(len);
        phy_rx_er     = er;
        bus_wr        = wr;
        bus_addr      = a;
        inc[0] = fd && cb;
        inc[1] = m_er_q && !m_er_high;
        inc[2] = fd && (len < 64);
        for (int i = 0; i < 3; i++) begin
            clr[i] = wr && (addr_index(a) == i);
            if (clr[i]) begin
                exp_w[i] = 0;
                exp_n[i] = 0;
            end else if (inc[i]) begin
                exp_w[i] = sat_step(exp_w[i], MAX_W);
                exp_n[i] = sat_step(exp_n[i], MAX_N);
            end
        end
        m_er_high = m_er_q;
        m_er_q    = er;
        @(posedge clk);
        @(negedge clk);
        rx_frame_done = 1'b0;
        rx_crc_bad    = 1'b0;
        bus_wr        = 1'b0;
    endtask

    task automatic rd_chk(logic [3:0] a, string req);
        int idx;
        int unsigned ew;
        int unsigned en;
        idx = addr_index(a);
        ew = (idx < 0) ? 0 : exp_w[idx];
        en = (idx < 0) ? 0 : exp_n[idx];
        bus_addr = a;
        bus_rd   = 1'b1;
        #1;
        compare(req, $sformatf("wide addr=%0h", a), rdata_w, ew);
        compare(req, $sformatf("narrow addr=%0h", a), rdata_n, en);
        bus_rd = 1'b0;
        #1;
    endtask

    task automatic rd_all(string req);
        rd_chk(4'h0, req);
        rd_chk(4'h4, req);
        rd_chk(4'h8, req);
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 3; i++) begin
            exp_w[i] = 0;
            exp_n[i] = 0;
        end
        m_er_q = 0;
        m_er_high = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_all("R1");
        // R9: unmapped read; R10: idle read data
        rd_chk(4'hC, "R9");
        bus_addr = 4'h0;
        #1;
        compare("R10", "idle rdata", rdata_w, 0);

        // R2: CRC frames of legal length
        repeat (3) cyc(1, 1, 100, 0, 0, 4'h0);
        cyc(1, 0, 100, 0, 0, 4'h0);
        rd_all("R2");
        rd_chk(4'h0, "R10");

        // R4: 63 counts, 64 does not
        cyc(1, 0, 63, 0, 0, 4'h0);
        rd_chk(4'h8, "R4");
        cyc(1, 0, 64, 0, 0, 4'h0);
        rd_chk(4'h8, "R4");

        // R5: short and CRC-bad together
        cyc(1, 1, 10, 0, 0, 4'h0);
        rd_all("R5");

        // R3: long high period counts once, latency two edges
        cyc(0, 0, 0, 1, 0, 4'h0);
        rd_chk(4'h4, "R3");
        cyc(0, 0, 0, 1, 0, 4'h0);
        rd_chk(4'h4, "R3");
        repeat (5) cyc(0, 0, 0, 1, 0, 4'h0);
        cyc(0, 0, 0, 0, 0, 4'h0);
        cyc(0, 0, 0, 1, 0, 4'h0);
        repeat (2) cyc(0, 0, 0, 0, 0, 4'h0);
        rd_chk(4'h4, "R3");

        // R7: clear one counter only
        cyc(0, 0, 0, 0, 1, 4'h4);
        rd_all("R7");
        // R8: clear with simultaneous increment
        cyc(1, 1, 20, 0, 1, 4'h0);
        rd_all("R8");
        // R9: writes to unmapped addresses change nothing
        cyc(0, 0, 0, 0, 1, 4'h1);
        cyc(0, 0, 0, 0, 1, 4'hC);
        rd_all("R9");

        // R6: saturate the narrow copy, hold, then clear and resume
        repeat (20) cyc(1, 1, 30, 0, 0, 4'h0);
        rd_chk(4'h0, "R6");
        cyc(0, 0, 0, 0, 1, 4'h0);
        cyc(1, 1, 30, 0, 0, 4'h0);
        rd_chk(4'h0, "R6");

        // mixed random traffic
        for (int n = 0; n < 4000; n++) begin
            bit fd;
            bit cb;
            int len;
            bit er;
            bit wr;
            logic [3:0] a;
            fd  = ($urandom_range(0, 9) < 4);
            cb  = $urandom_range(0, 1);
            len = ($urandom_range(0, 3) == 0) ? $urandom_range(60, 68)
                                             : $urandom_range(0, 1600);
            er  = ($urandom_range(0, 3) == 0) ? !phy_rx_er : phy_rx_er;
            wr  = ($urandom_range(0, 24) == 0);
            a   = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15))
                                             : 4'(4 * $urandom_range(0, 2));
            cyc(fd, cb, len, er, wr, a);
            case (n % 4)
                0: rd_chk(4'h0, "R2");
                1: rd_chk(4'h4, "R3");
                2: rd_chk(4'h8, "R4");
                default: rd_chk(4'($urandom_range(0, 15)), "R9");
            endcase
        end
        rd_all("R6");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule